// File: doc/BRIEF.md
# Memory Operand Address Generator

This block turns the addressing bytes of an instruction into the linear address of its memory operand. It takes the ModRM byte, a five-byte window of the bytes that follow it, the eight general register values, the six segment base addresses, an address-size select and a segment override field. From these it returns the operand offset, the segment chosen, the linear address and the number of bytes after ModRM that addressing used, so that the fetch stage can step past them.

Both address-size schemes are supported. In 16-bit mode the r/m field picks one of eight register sums, the sum wraps at 16 bits, and forms built on BP fall back on the stack segment. In 32-bit mode a general register serves as the base, with two escapes: r/m=4 brings in a scale-index-base byte, and the no-base encodings take a 32-bit displacement in place of a register. A request is accepted in one cycle and its result is registered, so the result appears on the next cycle. Register-direct operands (mod=3) are not memory operands and produce no result.

Register numbering (used for the register and segment buses): register n sits at `gpr[n*32 +: 32]`, with 0=EAX, 1=ECX, 2=EDX, 3=EBX, 4=ESP, 5=EBP, 6=ESI, 7=EDI. Segment n sits at `seg_base[n*32 +: 32]`, with 0=ES, 1=CS, 2=SS, 3=DS, 4=FS, 5=GS.

Top module: `mem_operand_agen`

## Requirements
- R1: After reset `res_valid` is 0. A request with `req_valid`=1 and mod (ModRM[7:6]) not equal to 3 makes `res_valid`=1 with its results on the next cycle. A request with mod=3 makes no result: `res_valid` stays 0.
- R2: In 16-bit mode (`addr32`=0) r/m (ModRM[2:0]) selects 0=BX+SI, 1=BX+DI, 2=BP+SI, 3=BP+DI, 4=SI, 5=DI, 6=BP, 7=BX, taken from the low 16 bits of the registers. The sum with displacement wraps to 16 bits, and `offset[31:16]` is 0.
- R3: In 16-bit mode, mod=0 with r/m=6 uses no register: the offset is the 16-bit displacement at window bytes 0..1, the default segment is DS, and 2 bytes are used.
- R4: In 16-bit mode, r/m 2 and 3 (any mod) and r/m 6 with mod 1 or 2 default to SS; every other form defaults to DS.
- R5: mod=1 adds the window byte after any scale-index-base byte, sign-extended. mod=2 adds a little-endian displacement of 16 bits (16-bit mode) or 32 bits (32-bit mode) starting at the same place.
- R6: In 32-bit mode with r/m other than 4, and not mod=0 with r/m=5, the register numbered r/m is the base. A base of ESP or EBP defaults to SS; any other base defaults to DS.
- R7: In 32-bit mode, mod=0 with r/m=5 gives an offset equal to the 32-bit displacement at window bytes 0..3, with default segment DS.
- R8: In 32-bit mode r/m=4 reads window byte 0 as scale-index-base: base in bits [2:0], index in bits [5:3], scale in bits [7:6]. The index register shifted left by the scale is added, except that index 4 adds nothing.
- R9: With scale-index-base present, base 5 and mod=0 adds no base register but a 32-bit displacement at window bytes 1..4, with default segment DS. Base 5 with mod 1 or 2 uses EBP and SS.
- R10: A nonzero `seg_ovr` (1..6) selects segment `seg_ovr`-1 in place of the default, and `seg_sel` reports it.
- R11: `lin_addr` equals `offset` plus the base of the selected segment, modulo 2^32.
- R12: `extra_bytes` equals one for a scale-index-base byte plus the displacement length (0, 1, 2 or 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe for one cycle |
| addr32 | input | 1 | 1 = 32-bit addressing, 0 = 16-bit addressing |
| modrm | input | 8 | ModRM byte |
| win | input | 40 | Bytes after ModRM, byte k at bits [8k+7:8k] |
| gpr | input | 256 | Eight general registers, 32 bits each |
| seg_base | input | 192 | Six segment base addresses, 32 bits each |
| seg_ovr | input | 3 | 0 = default segment, n = segment n-1 |
| res_valid | output | 1 | Result valid |
| offset | output | 32 | Effective offset |
| seg_sel | output | 3 | Segment used |
| lin_addr | output | 32 | Linear address |
| extra_bytes | output | 3 | Bytes used after ModRM |

## Verification
The assertions take for granted that `seg_ovr` never exceeds 6 while a request is made, and that every input is driven to a known value during reset, since several properties compare results against request inputs one cycle back. The bench drives all inputs at the falling edge with override values only in 0..6, keeps `req_valid` low through reset, and returns it to 0 after each single-cycle request.

// File: rtl/mem_operand_agen.sv
module mem_operand_agen #(
  parameter int XLEN = 32,
  parameter int NGPR = 8,
  parameter int NSEG = 6,
  parameter int WINB = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 addr32,
  input  logic [7:0]           modrm,
  input  logic [WINB*8-1:0]    win,
  input  logic [NGPR*XLEN-1:0] gpr,
  input  logic [NSEG*XLEN-1:0] seg_base,
  input  logic [2:0]           seg_ovr,
  output logic                 res_valid,
  output logic [XLEN-1:0]      offset,
  output logic [2:0]           seg_sel,
  output logic [XLEN-1:0]      lin_addr,
  output logic [2:0]           extra_bytes
);
  localparam logic [2:0] SEG_SS = 3'd2;
  localparam logic [2:0] SEG_DS = 3'd3;

  logic [1:0] md;
  logic [2:0] rm;
  assign md = modrm[7:6];
  assign rm = modrm[2:0];

  function automatic logic [XLEN-1:0] rd(input logic [NGPR*XLEN-1:0] f, input logic [2:0] n);
    return f[n*XLEN +: XLEN];
  endfunction

  // 16-bit path
  logic [15:0] bx, bp, si, di, b16, d16, sum16;
  logic [2:0]  nb16;
  logic        ss16;
  assign bx = rd(gpr, 3'd3)[15:0];
  assign bp = rd(gpr, 3'd5)[15:0];
  assign si = rd(gpr, 3'd6)[15:0];
  assign di = rd(gpr, 3'd7)[15:0];

  always_comb begin
    case (rm)
      3'd0: b16 = bx + si;
      3'd1: b16 = bx + di;
      3'd2: b16 = bp + si;
      3'd3: b16 = bp + di;
      3'd4: b16 = si;
      3'd5: b16 = di;
      3'd6: b16 = (md == 2'd0) ? 16'h0 : bp;
      default: b16 = bx;
    endcase
    case (md)
      2'd1: begin d16 = {{8{win[7]}}, win[7:0]}; nb16 = 3'd1; end
      2'd2: begin d16 = win[15:0]; nb16 = 3'd2; end
      default: begin
        d16  = (rm == 3'd6) ? win[15:0] : 16'h0;
        nb16 = (rm == 3'd6) ? 3'd2 : 3'd0;
      end
    endcase
    ss16  = (rm == 3'd2) || (rm == 3'd3) || (rm == 3'd6 && md != 2'd0);
    sum16 = b16 + d16;
  end

  // 32-bit path
  logic            has_sib, has_base, disp32_only;
  logic [7:0]      sib;
  logic [2:0]      base_n;
  logic [XLEN-1:0] base_v, idx_v, d32, dwin, sum32;
  logic [7:0]      d8;
  logic [2:0]      nb32;

  assign has_sib = (rm == 3'd4);
  assign sib     = win[7:0];
  assign d8      = has_sib ? win[15:8] : win[7:0];
  assign dwin    = has_sib ? win[39:8] : win[31:0];

  always_comb begin
    base_n      = has_sib ? sib[2:0] : rm;
    disp32_only = (md == 2'd0) && (base_n == 3'd5);
    has_base    = !disp32_only;
    base_v      = has_base ? rd(gpr, base_n) : '0;
    if (has_sib && sib[5:3] != 3'd4)
      idx_v = rd(gpr, sib[5:3]) << sib[7:6];
    else
      idx_v = '0;
    case (md)
      2'd1: begin d32 = {{(XLEN-8){d8[7]}}, d8}; nb32 = 3'd1; end
      2'd2: begin d32 = dwin; nb32 = 3'd4; end
      default: begin
        d32  = disp32_only ? dwin : '0;
        nb32 = disp32_only ? 3'd4 : 3'd0;
      end
    endcase
    sum32 = base_v + idx_v + d32;
  end

  logic [XLEN-1:0] off_c;
  logic [2:0]      seg_c, nb_c;
  logic            ss32;
  assign ss32  = has_base && (base_n == 3'd4 || base_n == 3'd5);
  assign off_c = addr32 ? sum32 : {{(XLEN-16){1'b0}}, sum16};
  assign nb_c  = addr32 ? (nb32 + {2'b0, has_sib}) : nb16;
  assign seg_c = (seg_ovr != 3'd0) ? (seg_ovr - 3'd1)
               : ((addr32 ? ss32 : ss16) ? SEG_SS : SEG_DS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      offset      <= '0;
      seg_sel     <= '0;
      lin_addr    <= '0;
      extra_bytes <= '0;
    end else begin
      res_valid <= req_valid && (md != 2'd3);
      if (req_valid && md != 2'd3) begin
        offset      <= off_c;
        seg_sel     <= seg_c;
        lin_addr    <= off_c + seg_base[seg_c*XLEN +: XLEN];
        extra_bytes <= nb_c;
      end
    end
  end

  // R1: a result follows exactly the memory-form requests
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (res_valid == $past(req_valid && modrm[7:6] != 2'd3)));
  // R2: 16-bit results never carry high bits
  a_r2_wrap16: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !$past(addr32)) |-> (offset[31:16] == 16'h0));
  // R10: override wins over the default segment
  a_r10_override: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(seg_ovr) != 3'd0) |-> (seg_sel == $past(seg_ovr) - 3'd1));
  // R12: never more than a SIB byte and four displacement bytes
  a_r12_bytes_bound: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (extra_bytes <= 3'd5));
  // R4: a 16-bit request without override lands on SS or DS only
  a_r4_seg16_range: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !$past(addr32) && $past(seg_ovr) == 3'd0) |->
      (seg_sel == SEG_SS || seg_sel == SEG_DS));
  // R11: selected segment stays in range
  a_r11_seg_range: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (seg_sel < 3'(NSEG)));
endmodule

// File: tb/mem_operand_agen_test.sv
module mem_operand_agen_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         addr32 = 1'b0;
  logic [7:0]   modrm = 8'h0;
  logic [39:0]  win = '0;
  logic [255:0] gpr;
  logic [191:0] seg_base;
  logic [2:0]   seg_ovr = 3'd0;
  logic         res_valid;
  logic [31:0]  offset, lin_addr;
  logic [2:0]   seg_sel, extra_bytes;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  localparam logic [31:0] EAX = 32'h0000_1000, ECX = 32'h0000_0200, EDX = 32'h0000_0030,
                          EBX = 32'h0000_1234, ESP = 32'h0000_8000, EBP = 32'h0000_2000,
                          ESI = 32'h0000_0100, EDI = 32'h0000_F000;
  localparam logic [31:0] SB_ES = 32'h0001_0000, SB_CS = 32'h0002_0000, SB_SS = 32'h0003_0000,
                          SB_DS = 32'h0004_0000, SB_FS = 32'h0005_0000, SB_GS = 32'h0006_0000;

  assign gpr = {EDI, ESI, EBP, ESP, EBX, EDX, ECX, EAX};
  assign seg_base = {SB_GS, SB_FS, SB_DS, SB_SS, SB_CS, SB_ES};

  always #2.5 clk = ~clk;

  mem_operand_agen uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .addr32(addr32), .modrm(modrm),
    .win(win), .gpr(gpr), .seg_base(seg_base), .seg_ovr(seg_ovr),
    .res_valid(res_valid), .offset(offset), .seg_sel(seg_sel),
    .lin_addr(lin_addr), .extra_bytes(extra_bytes)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic a32, input logic [7:0] m, input logic [39:0] w, input logic [2:0] ov);
    @(negedge clk);
    addr32 = a32; modrm = m; win = w; seg_ovr = ov; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_res(input string req, input logic [31:0] off, input logic [2:0] seg,
                            input logic [31:0] sbase, input logic [2:0] nb);
    chk(req, "valid", {31'b0, res_valid}, 32'd1);
    chk(req, "offset", offset, off);
    chk(req, "segment", {29'b0, seg_sel}, {29'b0, seg});
    chk("R11", "linear", lin_addr, off + sbase);
    chk("R12", "bytes", {29'b0, extra_bytes}, {29'b0, nb});
  endtask

  task automatic t_reset();
    chk("R1", "valid in reset", {31'b0, res_valid}, 32'd0);
  endtask

  task automatic t_16_pairs();
    issue(1'b0, 8'b00_000_000, '0, 3'd0);
    expect_res("R2", (EBX + ESI) & 32'hFFFF, 3'd3, SB_DS, 3'd0);
    issue(1'b0, 8'b00_000_011, '0, 3'd0);
    expect_res("R4", (EBP + EDI) & 32'hFFFF, 3'd2, SB_SS, 3'd0);
    issue(1'b0, 8'b10_000_111, 40'h00_0000_F000, 3'd0);
    expect_res("R2", (EBX + 32'hF000) & 32'hFFFF, 3'd3, SB_DS, 3'd2);
  endtask

  task automatic t_16_direct();
    issue(1'b0, 8'b00_000_110, 40'h00_0000_BEEF, 3'd0);
    expect_res("R3", 32'h0000_BEEF, 3'd3, SB_DS, 3'd2);
    issue(1'b0, 8'b01_000_110, 40'h00_0000_00FE, 3'd0);
    expect_res("R5", (EBP - 32'd2) & 32'hFFFF, 3'd2, SB_SS, 3'd1);
  endtask

  task automatic t_32_base();
    issue(1'b1, 8'b00_000_011, '0, 3'd0);
    expect_res("R6", EBX, 3'd3, SB_DS, 3'd0);
    issue(1'b1, 8'b01_000_101, 40'h00_0000_0080, 3'd0);
    expect_res("R6", EBP - 32'h80, 3'd2, SB_SS, 3'd1);
    issue(1'b1, 8'b10_000_010, 40'h00_8765_4321, 3'd0);
    expect_res("R5", EDX + 32'h8765_4321, 3'd3, SB_DS, 3'd4);
    issue(1'b1, 8'b00_000_101, 40'h00_1234_5678, 3'd0);
    expect_res("R7", 32'h1234_5678, 3'd3, SB_DS, 3'd4);
  endtask

  task automatic t_32_sib();
    issue(1'b1, 8'b10_000_100, {8'h00, 32'h0000_0010, 8'h88}, 3'd0);
    expect_res("R8", EAX + (ECX << 2) + 32'h10, 3'd3, SB_DS, 3'd5);
    issue(1'b1, 8'b00_000_100, {32'h0, 8'h24}, 3'd0);
    expect_res("R8", ESP, 3'd2, SB_SS, 3'd1);
    issue(1'b1, 8'b00_000_100, {8'h00, 32'hAABB_0000, 8'hF5}, 3'd0);
    expect_res("R9", 32'hAABB_0000 + (ESI << 3), 3'd3, SB_DS, 3'd5);
    issue(1'b1, 8'b01_000_100, {24'h0, 8'h04, 8'h25}, 3'd0);
    expect_res("R9", EBP + 32'h4, 3'd2, SB_SS, 3'd2);
  endtask

  task automatic t_override();
    issue(1'b1, 8'b00_000_101, 40'h00_0000_0040, 3'd5);
    expect_res("R10", 32'h40, 3'd4, SB_FS, 3'd4);
    issue(1'b0, 8'b00_000_010, '0, 3'd1);
    expect_res("R10", (EBP + ESI) & 32'hFFFF, 3'd0, SB_ES, 3'd0);
  endtask

  task automatic t_wrap_and_reg();
    issue(1'b1, 8'b00_000_101, 40'h00_FFFF_0000, 3'd6);
    expect_res("R11", 32'hFFFF_0000, 3'd5, SB_GS, 3'd4);
    chk("R11", "wrapped linear", lin_addr, 32'h0005_0000);
    issue(1'b1, 8'b11_000_011, '0, 3'd0);
    chk("R1", "mod3 no result", {31'b0, res_valid}, 32'd0);
    @(negedge clk);
    chk("R1", "idle", {31'b0, res_valid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_16_pairs();
    t_16_direct();
    t_32_base();
    t_32_sib();
    t_override();
    t_wrap_and_reg();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule